// File: doc/BRIEF.md
# Flash Status Register with Sticky Fail Flags

This block keeps the 8-bit status word that a flash controller returns to the host during status reads. An operation engine reports three things: its busy level, one-cycle pulses when an erase or a program attempt fails, and the current sector-protect state. A command decoder sends a one-cycle clear pulse. The host side provides active-low chip-enable and output-enable read strobes and a byte/word width select. All of these inputs are sampled on the block clock.

Fail flags are sticky. They build up over a whole batch of operations, so one status read at the end shows whether any step in the batch failed. Only the clear command removes them. While either flag is set, the block raises an inhibit output that the engine uses to refuse new program or erase starts.

The word presented to the host is captured once per read access, at the moment the second of the two strobes goes active. It then stays fixed until the host ends the access. In word mode the upper byte reads as zero. In byte mode its drive enable stays low.

Top module: `flash_stat_reg`

## Requirements
- R1: After reset, a status read returns 0x0080 (bit 7 ready = 1, bits 6..4 = 0, bit 3 = protect input, which is 0 in reset). The inhibit output and both drive enables are 0.
- R2: Bit 7 is the inverse of the engine busy input, registered one clock later. Bit 6 and bits 2..0 always read 0.
- R3: An erase-fail pulse sets bit 5. Bit 5 then stays set through later busy changes and later program-fail pulses, until a clear pulse arrives.
- R4: A program-fail pulse sets bit 4. Bit 4 then stays set through later busy changes and later erase-fail pulses, until a clear pulse arrives.
- R5: A clear pulse resets bits 5 and 4. If a fail pulse arrives in the same clock as the clear, that fail flag ends up set.
- R6: Bit 3 follows the protect input one clock later. A clear pulse does not change it.
- R7: The read word is captured on the clock where both strobes are first seen low together. This holds whichever strobe falls last. The value is the status as registered before that edge and appears on the data output one clock later.
- R8: While both strobes stay low, the read data does not change, even if the status changes. Raising either strobe and lowering it again captures a fresh value.
- R9: The low-byte drive enable is 1 one clock after both strobes are seen low, and 0 one clock after either is seen high. In word mode (byte_mode = 0) the high-byte enable equals the low-byte enable and bits 15..8 read 0x00. In byte mode the high-byte enable stays 0.
- R10: The inhibit output is 1 exactly while bit 5 or bit 4 is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| eng_busy | input | 1 | Engine busy level |
| eng_erase_fail | input | 1 | One-cycle erase failure pulse |
| eng_prog_fail | input | 1 | One-cycle program failure pulse |
| sect_prot | input | 1 | Sector-protect state |
| clr_stat | input | 1 | One-cycle clear-status command pulse |
| ce_n | input | 1 | Chip-enable read strobe, active low |
| oe_n | input | 1 | Output-enable read strobe, active low |
| byte_mode | input | 1 | 1 = byte-wide bus, 0 = word-wide bus |
| rd_data | output | 16 | Captured status word for the read bus |
| rd_lo_oe | output | 1 | Drive enable for bits 7..0 |
| rd_hi_oe | output | 1 | Drive enable for bits 15..8 |
| start_inhibit | output | 1 | Blocks new program or erase starts |

## Verification
The main sweep walks all sixteen combinations of busy, erase fail, program fail and protect. Each combination is read in word mode and in byte mode, and the strobe order alternates. This separates a bit-position or polarity error on any single status bit from an error in the upper-byte handling.

Further patterns target specific behaviour:
- A fail is injected between the first and the second strobe fall. This tells capture-at-last-strobe apart from capture-at-first-strobe.
- A fail is injected while a read is open, and the strobe is then re-toggled. This shows the value being held and then refreshed.
- A clear and a fail arrive in the same clock, and a clear is issued with protect high. These pin down set priority and the protect bit's immunity to clear.

// File: rtl/flash_stat_pkg.sv
package flash_stat_pkg;

  localparam int STAT_W    = 8;
  localparam int RDY_BIT   = 7;
  localparam int EFAIL_BIT = 5;
  localparam int PFAIL_BIT = 4;
  localparam int PROT_BIT  = 3;

  // flag slots inside the sticky bank
  localparam int FLAG_PFAIL = 0;
  localparam int FLAG_EFAIL = 1;
  localparam int NUM_FLAGS  = 2;

  typedef struct packed {
    logic       ready;
    logic       rsvd6;
    logic       efail;
    logic       pfail;
    logic       prot;
    logic [2:0] rsvd_lo;
  } stat_word_t;

endpackage

// File: rtl/fst_sticky_flags.sv
module fst_sticky_flags #(
  parameter int NUM = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NUM-1:0] set_pulse,
  input  logic           clr,
  output logic [NUM-1:0] flag_q
);

  logic [NUM-1:0] flag_d;

  for (genvar g = 0; g < NUM; g++) begin : g_flag
    // a set in the same cycle as a clear wins so no failure is lost
    always_comb begin
      flag_d[g] = flag_q[g];
      if (clr) flag_d[g] = 1'b0;
      if (set_pulse[g]) flag_d[g] = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flag_q[g] <= 1'b0;
      else        flag_q[g] <= flag_d[g];
    end
  end

endmodule

// File: rtl/fst_live_word.sv
module fst_live_word
  import flash_stat_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 busy,
  input  logic                 prot,
  input  logic [NUM_FLAGS-1:0] flags,
  output stat_word_t           live
);

  logic ready_q, ready_d;
  logic prot_q, prot_d;

  always_comb begin
    ready_d = ~busy;
    prot_d  = prot;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ready_q <= 1'b1;
      prot_q  <= 1'b0;
    end else begin
      ready_q <= ready_d;
      prot_q  <= prot_d;
    end
  end

  always_comb begin
    live         = '0;
    live.ready   = ready_q;
    live.efail   = flags[FLAG_EFAIL];
    live.pfail   = flags[FLAG_PFAIL];
    live.prot    = prot_q;
  end

endmodule

// File: rtl/fst_read_snap.sv
module fst_read_snap
  import flash_stat_pkg::*;
#(
  parameter int BUS_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ce_n,
  input  logic             oe_n,
  input  logic             byte_mode,
  input  stat_word_t       live,
  output logic [BUS_W-1:0] rd_data,
  output logic             rd_lo_oe,
  output logic             rd_hi_oe
);

  localparam int HI_W = BUS_W - STAT_W;

  logic       strobe_now;
  logic       act_q, act_d;
  logic       hi_q, hi_d;
  logic       cap_en;
  stat_word_t snap_q, snap_d;

  always_comb begin
    strobe_now = ~ce_n & ~oe_n;
    cap_en     = strobe_now & ~act_q;
    act_d      = strobe_now;
    hi_d       = strobe_now & ~byte_mode;
    snap_d     = cap_en ? live : snap_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      hi_q   <= 1'b0;
      snap_q <= '0;
    end else begin
      act_q  <= act_d;
      hi_q   <= hi_d;
      snap_q <= snap_d;
    end
  end

  assign rd_data[STAT_W-1:0] = snap_q;
  if (HI_W > 0) begin : g_hi
    assign rd_data[BUS_W-1:STAT_W] = '0;
  end
  assign rd_lo_oe = act_q;
  assign rd_hi_oe = hi_q;

endmodule

// File: rtl/flash_stat_reg.sv
module flash_stat_reg
  import flash_stat_pkg::*;
#(
  parameter int BUS_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             eng_busy,
  input  logic             eng_erase_fail,
  input  logic             eng_prog_fail,
  input  logic             sect_prot,
  input  logic             clr_stat,
  input  logic             ce_n,
  input  logic             oe_n,
  input  logic             byte_mode,
  output logic [BUS_W-1:0] rd_data,
  output logic             rd_lo_oe,
  output logic             rd_hi_oe,
  output logic             start_inhibit
);

  logic [SYNC_STAGES-1:0] rst_pipe;
  logic                   rst_sync_n;
  logic [NUM_FLAGS-1:0]   fail_set;
  logic [NUM_FLAGS-1:0]   fail_q;
  stat_word_t             live_stat;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[SYNC_STAGES-2:0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[SYNC_STAGES-1];

  always_comb begin
    fail_set             = '0;
    fail_set[FLAG_PFAIL] = eng_prog_fail;
    fail_set[FLAG_EFAIL] = eng_erase_fail;
  end

  fst_sticky_flags #(.NUM(NUM_FLAGS)) u_flags (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .set_pulse (fail_set),
    .clr       (clr_stat),
    .flag_q    (fail_q)
  );

  fst_live_word u_live (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .busy  (eng_busy),
    .prot  (sect_prot),
    .flags (fail_q),
    .live  (live_stat)
  );

  fst_read_snap #(.BUS_W(BUS_W)) u_snap (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .ce_n      (ce_n),
    .oe_n      (oe_n),
    .byte_mode (byte_mode),
    .live      (live_stat),
    .rd_data   (rd_data),
    .rd_lo_oe  (rd_lo_oe),
    .rd_hi_oe  (rd_hi_oe)
  );

  assign start_inhibit = |fail_q;

endmodule

// File: rtl/flash_stat_reg_chk.sv
module flash_stat_reg_chk #(
  parameter int BUS_W = 16
) (
  input logic             clk,
  input logic             rst_ok,
  input logic             eng_erase_fail,
  input logic             eng_prog_fail,
  input logic             clr_stat,
  input logic             ce_n,
  input logic             oe_n,
  input logic [7:0]       live_bits,
  input logic [BUS_W-1:0] rd_data,
  input logic             rd_lo_oe,
  input logic             rd_hi_oe,
  input logic             start_inhibit
);

  assert_zero_bits_R2: assert property (@(posedge clk) disable iff (!rst_ok)
    rd_lo_oe |-> (rd_data[6] == 1'b0 && rd_data[2:0] == 3'b000));

  assert_efail_sticky_R3: assert property (@(posedge clk) disable iff (!rst_ok)
    (live_bits[5] && !clr_stat) |=> live_bits[5]);

  assert_pfail_sticky_R4: assert property (@(posedge clk) disable iff (!rst_ok)
    (live_bits[4] && !clr_stat) |=> live_bits[4]);

  assert_set_wins_R5: assert property (@(posedge clk) disable iff (!rst_ok)
    eng_erase_fail |=> live_bits[5]);

  assert_clear_R5: assert property (@(posedge clk) disable iff (!rst_ok)
    (clr_stat && !eng_erase_fail && !eng_prog_fail) |=> (!live_bits[5] && !live_bits[4]));

  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_ok)
    (!ce_n && !oe_n && rd_lo_oe) |=> $stable(rd_data));

  assert_hi_oe_R9: assert property (@(posedge clk) disable iff (!rst_ok)
    rd_hi_oe |-> (rd_lo_oe && rd_data[BUS_W-1:8] == '0));

  assert_inhibit_rise_R10: assert property (@(posedge clk) disable iff (!rst_ok)
    $rose(start_inhibit) |-> $past(eng_erase_fail || eng_prog_fail));

endmodule

bind flash_stat_reg flash_stat_reg_chk #(.BUS_W(BUS_W)) u_chk (
  .clk            (clk),
  .rst_ok         (rst_sync_n),
  .eng_erase_fail (eng_erase_fail),
  .eng_prog_fail  (eng_prog_fail),
  .clr_stat       (clr_stat),
  .ce_n           (ce_n),
  .oe_n           (oe_n),
  .live_bits      (live_stat),
  .rd_data        (rd_data),
  .rd_lo_oe       (rd_lo_oe),
  .rd_hi_oe       (rd_hi_oe),
  .start_inhibit  (start_inhibit)
);

// File: tb/flash_stat_reg_tb.sv
`timescale 1ns/1ps
module flash_stat_reg_tb;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        eng_busy, eng_erase_fail, eng_prog_fail, sect_prot, clr_stat;
  logic        ce_n, oe_n, byte_mode;
  logic [15:0] rd_data;
  logic        rd_lo_oe, rd_hi_oe, start_inhibit;

  int total = 0;
  int bad   = 0;

  // bench model of the live status
  logic m_rdy, m_ef, m_pf, m_prot;

  always #2 clk = ~clk;

  flash_stat_reg u_dut (
    .clk(clk), .rst_n(rst_n), .eng_busy(eng_busy), .eng_erase_fail(eng_erase_fail),
    .eng_prog_fail(eng_prog_fail), .sect_prot(sect_prot), .clr_stat(clr_stat),
    .ce_n(ce_n), .oe_n(oe_n), .byte_mode(byte_mode), .rd_data(rd_data),
    .rd_lo_oe(rd_lo_oe), .rd_hi_oe(rd_hi_oe), .start_inhibit(start_inhibit)
  );

  function automatic logic [15:0] exp_word();
    return {8'h00, m_rdy, 1'b0, m_ef, m_pf, m_prot, 3'b000};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
  endtask

  task automatic pulse_fail(input logic ef, input logic pf, input logic clr);
    eng_erase_fail = ef; eng_prog_fail = pf; clr_stat = clr;
    cyc();
    eng_erase_fail = 1'b0; eng_prog_fail = 1'b0; clr_stat = 1'b0;
    if (clr) begin m_ef = 1'b0; m_pf = 1'b0; end
    if (ef) m_ef = 1'b1;
    if (pf) m_pf = 1'b1;
  endtask

  // opens a read with the chosen strobe first; returns with both low
  task automatic open_read(input logic ce_first);
    if (ce_first) ce_n = 1'b0; else oe_n = 1'b0;
    cyc();
    ce_n = 1'b0; oe_n = 1'b0;
    cyc();
  endtask

  task automatic close_read();
    ce_n = 1'b1; oe_n = 1'b1;
    cyc();
  endtask

  initial begin
    #800000;
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; eng_busy = 1'b0; eng_erase_fail = 1'b0; eng_prog_fail = 1'b0;
    sect_prot = 1'b0; clr_stat = 1'b0; ce_n = 1'b1; oe_n = 1'b1; byte_mode = 1'b0;
    m_rdy = 1'b1; m_ef = 1'b0; m_pf = 1'b0; m_prot = 1'b0;
    repeat (3) cyc();
    rst_n = 1'b1;
    repeat (4) cyc();

    // R1 reset state
    check("R1 inhibit", {31'd0, start_inhibit}, 32'd0);
    check("R1 oe", {30'd0, rd_lo_oe, rd_hi_oe}, 32'd0);
    open_read(1'b1);
    check("R1 word", {16'd0, rd_data}, 32'h0080);
    close_read();
    check("R9 idle oe", {30'd0, rd_lo_oe, rd_hi_oe}, 32'd0);

    // sweep of busy / erase fail / program fail / protect, both widths
    for (int i = 0; i < 16; i++) begin
      eng_busy = i[0]; sect_prot = i[3];
      pulse_fail(1'b0, 1'b0, 1'b1);
      if (i[1]) pulse_fail(1'b1, 1'b0, 1'b0);
      if (i[2]) pulse_fail(1'b0, 1'b1, 1'b0);
      m_rdy = ~i[0]; m_prot = i[3];
      cyc();
      byte_mode = 1'b0;
      open_read(i[0] ^ i[1]);
      check("R2 R3 R4 R6 R7 word", {16'd0, rd_data}, {16'd0, exp_word()});
      check("R9 word oe", {30'd0, rd_lo_oe, rd_hi_oe}, 32'd3);
      check("R10 inhibit", {31'd0, start_inhibit}, {31'd0, m_ef | m_pf});
      close_read();
      byte_mode = 1'b1;
      open_read(~(i[0] ^ i[1]));
      check("R2 byte", {24'd0, rd_data[7:0]}, {24'd0, exp_word()[7:0]});
      check("R9 byte oe", {30'd0, rd_lo_oe, rd_hi_oe}, 32'd2);
      close_read();
      byte_mode = 1'b0;
    end

    // R3 R4 stickiness across busy toggles and the other pulse
    eng_busy = 1'b0; sect_prot = 1'b1; m_rdy = 1'b1; m_prot = 1'b1;
    pulse_fail(1'b0, 1'b0, 1'b1);
    pulse_fail(1'b1, 1'b0, 1'b0);
    eng_busy = 1'b1; cyc(); eng_busy = 1'b0; cyc();
    pulse_fail(1'b0, 1'b1, 1'b0);
    cyc();
    open_read(1'b1);
    check("R3 R4 sticky", {16'd0, rd_data}, 32'h00B8);
    close_read();

    // R6 protect unaffected by clear; R5 clear
    pulse_fail(1'b0, 1'b0, 1'b1);
    cyc();
    open_read(1'b0);
    check("R5 R6 clear", {16'd0, rd_data}, 32'h0088);
    close_read();
    check("R10 released", {31'd0, start_inhibit}, 32'd0);

    // R5 simultaneous clear and fail: set wins
    pulse_fail(1'b1, 1'b0, 1'b1);
    cyc();
    open_read(1'b1);
    check("R5 set wins", {16'd0, rd_data}, 32'h00A8);
    close_read();
    pulse_fail(1'b0, 1'b1, 1'b1);
    cyc();
    open_read(1'b0);
    check("R5 set wins pf", {16'd0, rd_data}, 32'h0098);
    close_read();
    pulse_fail(1'b0, 1'b0, 1'b1);

    // R7 capture at the later strobe: fail lands between falls
    ce_n = 1'b0; cyc();
    pulse_fail(1'b1, 1'b0, 1'b0);
    cyc();
    oe_n = 1'b0; cyc();
    check("R7 later strobe", {16'd0, rd_data}, 32'h00A8);
    close_read();
    pulse_fail(1'b0, 1'b0, 1'b1);

    // R8 hold during read, then refresh on re-toggle
    open_read(1'b1);
    check("R8 before", {16'd0, rd_data}, 32'h0088);
    pulse_fail(1'b0, 1'b1, 1'b0);
    eng_busy = 1'b1; m_rdy = 1'b0;
    repeat (2) cyc();
    check("R8 held", {16'd0, rd_data}, 32'h0088);
    oe_n = 1'b1; cyc();
    oe_n = 1'b0; cyc();
    check("R8 refresh", {16'd0, rd_data}, 32'h0018);
    close_read();

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule